// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns pin transitions from four general-purpose I/O ports into a single prioritised interrupt request. It has sixteen interrupt lines. Line n listens to pin n of exactly one port, and a per-line select code chooses which port that is. Each line detects rising edges, falling edges or both. A detected edge sets a sticky pending bit. The request output names the lowest-numbered line that is both pending and enabled.

Software programs the block through a write-only register port. It handles a request by reading the active line index, running its handler, and writing a one to that line's bit in the clear register. Edges that arrive while another line is being serviced stay pending and are presented afterwards, lowest line first.

Top module: `exti_ctrl`

## Requirements
- R1: Line n is driven only by bit n of the port named by its 2-bit select field: code 0 is port A, 1 is port B, 2 is port C and 3 is port D. The field for line n sits at bits [2n+1:2n] of the register at address 0. Port p bit n is `gpio_i[p*16+n]`.
- R2: Bit n of address 1 enables rising-edge detection on line n. Bit n of address 2 enables falling-edge detection on line n. With both bits set, the line detects both edges. With neither bit set, the line detects no edges.
- R3: A pin change is synchronised and detected, and shows in `pending_o` at the third rising clock edge after the pin changes. It does not show at the second edge.
- R4: A pending bit is set whatever the mask says. It stays set until a one is written to the same bit at address 4. Zero bits in that write leave their pending bits unchanged.
- R5: If a clear and a new edge on the same line take effect at the same clock edge, the pending bit stays set.
- R6: `irq_o` is high exactly when some line is pending and has its enable bit set at address 3. `irq_idx_o` is then the lowest such line index.
- R7: Writing a new select code for a line does not set that line's pending bit, even when the old and new source pins differ.
- R8: After reset, every select code is 0, no edges are enabled, all lines are masked, no bit is pending and `irq_o` is low.
- R9: Transitions on pins of ports that a line does not select have no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gpio_i | input | 64 | Pins of ports A to D. Port p bit n is at index p*16+n |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 select, 1 rise, 2 fall, 3 mask, 4 clear |
| wr_data_i | input | 32 | Register write data |
| pending_o | output | 16 | Pending bits |
| irq_o | output | 1 | Interrupt request |
| irq_idx_o | output | 4 | Index of the presented line |

## Verification
The tests drive each kind of edge on its own: a rising pulse, a falling pulse, and a full toggle on a line set to both edges. This separates the two enable bits. Two lines fire in the same cycle to check that the lower index is presented first and that the higher one is presented after the lower one is cleared. A line is moved from port A to port B while the two pins differ, which exposes any edge the select change might create. A clear is timed to land on the same clock edge as a new edge. Pins on an unselected port are toggled and must have no effect. A step-by-step latency probe pins down the three-edge delay.

// File: rtl/exti_pkg.sv
package exti_pkg;
  localparam int unsigned EXTI_LINES = 16;
  localparam int unsigned EXTI_PORTS = 4;
  localparam int unsigned ADDR_W     = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SEL  = 3'd0,
    ADDR_RISE = 3'd1,
    ADDR_FALL = 3'd2,
    ADDR_MASK = 3'd3,
    ADDR_CLR  = 3'd4
  } exti_addr_e;
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] dst_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
    end
  end

  assign dst_o = sync_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni, 2) |-> dst_o == $past(src_i, 2)); // R3
endmodule

// File: rtl/exti_line.sv
module exti_line #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned SEL_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] pins_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 rise_en_i,
  input  logic                 fall_en_i,
  output logic                 edge_o
);
  logic cur, prev_q, mute;
  logic [SEL_W-1:0] sel_d_q;

  // out-of-range codes read as low
  always_comb begin
    cur = 1'b0;
    if (int'(sel_i) < NUM_PORTS) cur = pins_i[sel_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      sel_d_q <= '0;
    end else begin
      prev_q  <= cur;
      sel_d_q <= sel_i;
    end
  end

  // prev_q still holds the old source for one cycle after a select change
  assign mute   = (sel_i != sel_d_q);
  assign edge_o = !mute && ((rise_en_i && cur && !prev_q) ||
                            (fall_en_i && !cur && prev_q));

  AST_EDGE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> (rise_en_i || fall_en_i)); // R2
  AST_NO_EDGE_ON_RESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$stable(sel_i) |-> !edge_o); // R7
endmodule

// File: rtl/exti_arbiter.sv
module exti_arbiter #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |req_i;

  always_comb begin
    if (valid_o) begin
      AST_IDX_IS_REQUESTER: assert (req_i[idx_o]); // R6
    end
  end
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
  import exti_pkg::*;
#(
  parameter int unsigned NUM_LINES = EXTI_LINES,
  parameter int unsigned NUM_PORTS = EXTI_PORTS,
  localparam int unsigned SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES),
  localparam int unsigned DATA_W   = NUM_LINES * SEL_W,
  localparam int unsigned PIN_W    = NUM_LINES * NUM_PORTS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PIN_W-1:0]     gpio_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [NUM_LINES-1:0] pending_o,
  output logic                 irq_o,
  output logic [IDX_W-1:0]     irq_idx_o
);
  logic [DATA_W-1:0]    sel_q;
  logic [NUM_LINES-1:0] rise_q, fall_q, mask_q, pend_q;
  logic [NUM_LINES-1:0] clr_vec, edge_vec;
  logic [PIN_W-1:0]     gpio_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_SEL:  sel_q  <= wr_data_i;
        ADDR_RISE: rise_q <= wr_data_i[NUM_LINES-1:0];
        ADDR_FALL: fall_q <= wr_data_i[NUM_LINES-1:0];
        ADDR_MASK: mask_q <= wr_data_i[NUM_LINES-1:0];
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr_en_i && wr_addr_i == ADDR_CLR) ? wr_data_i[NUM_LINES-1:0] : '0;

  exti_sync #(.WIDTH(PIN_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (gpio_i),
    .dst_o  (gpio_s)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] pins;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign pins[p] = gpio_s[p*NUM_LINES + n];
    end

    exti_line #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pins_i    (pins),
      .sel_i     (sel_q[n*SEL_W +: SEL_W]),
      .rise_en_i (rise_q[n]),
      .fall_en_i (fall_q[n]),
      .edge_o    (edge_vec[n])
    );
  end

  // new edge beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_vec) | edge_vec;
  end

  exti_arbiter #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_arb (
    .req_i   (pend_q & mask_q),
    .valid_o (irq_o),
    .idx_o   (irq_idx_o)
  );

  assign pending_o = pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~pend_q & $past(pend_q & ~clr_vec)) == '0); // R4
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(clr_vec & edge_vec) |=> (pend_q & $past(clr_vec & edge_vec)) == $past(clr_vec & edge_vec)); // R5
  AST_IRQ_ENABLED_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_q[irq_idx_o] && mask_q[irq_idx_o]); // R6
endmodule

// File: tb/exti_ctrl_test.sv
module exti_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] gpio_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [15:0] pending_o;
  logic        irq_o;
  logic [3:0]  irq_idx_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  exti_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .gpio_i(gpio_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pending_o(pending_o), .irq_o(irq_o), .irq_idx_o(irq_idx_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_i);
  endtask

  task automatic pin(input int p, input int n, input logic v);
    @(negedge clk_i);
    gpio_i[p*16+n] = v;
  endtask

  task automatic t_reset();
    chk("R8 pending", 32'(pending_o), 0);
    chk("R8 irq", 32'(irq_o), 0);
    gpio_i[0] = 1'b1; settle();
    chk("R8 no edge enabled", 32'(pending_o), 0);
    gpio_i[0] = 1'b0; settle();
  endtask

  task automatic t_rise();
    wr(1, 32'h0002); wr(3, 32'hFFFF);
    pin(0, 1, 1'b1); settle();
    chk("R2 rising sets", 32'(pending_o), 32'h0002);
    chk("R6 irq idx", 32'(irq_idx_o), 1);
    wr(4, 32'h0002);
    pin(0, 1, 1'b0); settle();
    chk("R2 falling ignored on rise line", 32'(pending_o), 0);
    chk("R6 irq low", 32'(irq_o), 0);
  endtask

  task automatic t_fall_both();
    wr(1, 32'h0000); wr(2, 32'h0004);
    pin(0, 2, 1'b1); settle();
    chk("R2 rise ignored on fall line", 32'(pending_o), 0);
    pin(0, 2, 1'b0); settle();
    chk("R2 falling sets", 32'(pending_o), 32'h0004);
    wr(4, 32'h0004);
    wr(1, 32'h0004);
    pin(0, 2, 1'b1); settle();
    chk("R2 both rise", 32'(pending_o), 32'h0004);
    wr(4, 32'h0004);
    pin(0, 2, 1'b0); settle();
    chk("R2 both fall", 32'(pending_o), 32'h0004);
    wr(4, 32'h0004);
    wr(1, 0); wr(2, 0);
  endtask

  task automatic t_latency();
    wr(1, 32'h0008);
    @(negedge clk_i); gpio_i[3] = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk("R3 not after 2 edges", 32'(pending_o[3]), 0);
    @(negedge clk_i);
    chk("R3 set after 3 edges", 32'(pending_o[3]), 1);
    wr(4, 32'h0008); wr(1, 0);
    gpio_i[3] = 1'b0; settle();
  endtask

  task automatic t_port_select();
    // line 5 -> port C (code 2 at bits 11:10)
    wr(0, 32'h0000_0800); wr(1, 32'h0020);
    pin(0, 5, 1'b1); pin(1, 5, 1'b1); pin(3, 5, 1'b1); settle();
    chk("R9 other ports ignored", 32'(pending_o), 0);
    pin(2, 5, 1'b1); settle();
    chk("R1 port C drives line 5", 32'(pending_o), 32'h0020);
    wr(4, 32'h0020); wr(1, 0); wr(0, 0);
    gpio_i = '0; settle();
  endtask

  task automatic t_reselect();
    // line 7: port A low, port B high; switch A -> B
    wr(1, 32'h0080); wr(2, 32'h0080);
    pin(1, 7, 1'b1); settle();
    chk("R9 port B ignored while A", 32'(pending_o), 0);
    wr(0, 32'h0000_4000); settle();
    chk("R7 no spurious edge", 32'(pending_o), 0);
    pin(1, 7, 1'b0); settle();
    chk("R1 port B now drives line 7", 32'(pending_o), 32'h0080);
    wr(4, 32'h0080); wr(0, 0); wr(1, 0); wr(2, 0);
    gpio_i = '0; settle();
  endtask

  task automatic t_mask();
    wr(3, 32'h0000); wr(1, 32'h0008);
    pin(0, 3, 1'b1); settle();
    chk("R4 pending despite mask", 32'(pending_o), 32'h0008);
    chk("R6 masked no irq", 32'(irq_o), 0);
    wr(3, 32'h0008);
    chk("R6 enabled irq", 32'(irq_o), 1);
    chk("R6 idx 3", 32'(irq_idx_o), 3);
    wr(4, 32'h0000); settle();
    chk("R4 zero write keeps", 32'(pending_o), 32'h0008);
    wr(4, 32'h0008);
    chk("R4 one clears", 32'(pending_o), 0);
    wr(1, 0); gpio_i = '0; settle();
  endtask

  task automatic t_priority();
    wr(3, 32'hFFFF); wr(1, 32'h0210);
    @(negedge clk_i); gpio_i[4] = 1'b1; gpio_i[9] = 1'b1;
    settle();
    chk("R6 both pending", 32'(pending_o), 32'h0210);
    chk("R6 lowest first", 32'(irq_idx_o), 4);
    wr(4, 32'h0010);
    chk("R6 next line", 32'(irq_idx_o), 9);
    chk("R4 held line kept", 32'(pending_o), 32'h0200);
    wr(4, 32'h0200);
    chk("R6 idle", 32'(irq_o), 0);
    wr(1, 0); gpio_i = '0; settle();
  endtask

  task automatic t_clear_race();
    wr(1, 32'h0004); wr(2, 32'h0004);
    pin(0, 2, 1'b1); settle();
    chk("R5 precondition", 32'(pending_o), 32'h0004);
    @(negedge clk_i); gpio_i[2] = 1'b0;
    @(negedge clk_i);
    wr(4, 32'h0004);
    chk("R5 edge beats clear", 32'(pending_o), 32'h0004);
    wr(4, 32'h0004);
    chk("R5 later clear works", 32'(pending_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rise();
    t_fall_both();
    t_latency();
    t_port_select();
    t_reselect();
    t_mask();
    t_priority();
    t_clear_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule